// File: doc/BRIEF.md
# Configuration Write-Lock Controller

This block stands between a simple register-bus write port and a bank of memory-controller configuration registers. It decodes writes to one write-only control word, keeps a software lock that blocks writes into the protected bank, and holds a separate hardware lock class that only reset can clear. Writes that the locks allow reach the bank one cycle later through a gated write port.

The block also keeps the memory controller from taking requests after reset. The `req_accept` output stays low until software first writes the lock bit. After that, software may drop the configuration lock without a reset to rewrite settings, and request acceptance is not disturbed.

The protected bank is an aligned window of `BANK_SIZE` addresses starting at `BANK_BASE`. `BANK_SIZE` is a power of two, and the control word address lies outside the window.

Top module: `cwl_lock_ctrl`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it rises, `cfg_locked`, `sticky_locked`, `req_accept` and `cfg_wr_en` are all 0.
- R2: A write to `CTL_ADDR` with data bit 0 (the lock bit) set to 1 sets `cfg_locked` and `req_accept` on the following cycle.
- R3: `req_accept` stays 0 after reset until the first write that sets the lock bit. Protected writes, stray writes, unlock writes and control writes with data bits [1:0] = 00 do not raise it.
- R4: A write to an address in [`BANK_BASE`, `BANK_BASE`+`BANK_SIZE`) made while `cfg_locked` and `sticky_locked` are both 0 appears on the next cycle as `cfg_wr_en`=1, with `cfg_wr_addr` equal to the offset into the window and `cfg_wr_data` equal to the written data.
- R5: A protected write made while `cfg_locked` or `sticky_locked` is 1 is discarded. `cfg_wr_en` stays 0 on the next cycle.
- R6: A control write with data bits [1:0] = 10 (unlock only) clears `cfg_locked` on the next cycle and leaves `req_accept` unchanged.
- R7: A control write with data bits [1:0] = 11 acts as a lock, so the lock bit wins over the unlock bit.
- R8: Once set, `req_accept` stays 1 through any later unlock and relock writes until reset.
- R9: A pulse on `sticky_lock_req` sets `sticky_locked` on the next cycle. An unlock write does not clear it, and protected writes stay blocked. Only reset clears it.
- R10: Writes to addresses outside the window and not at `CTL_ADDR` never raise `cfg_wr_en` and change no lock state. A control write with data bits [1:0] = 00 changes no lock state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| reg_wr_en | input | 1 | Register-bus write strobe |
| reg_wr_addr | input | ADDR_W | Register-bus write address |
| reg_wr_data | input | DATA_W | Register-bus write data |
| sticky_lock_req | input | 1 | Hardware request for the sticky lock, which reset alone clears |
| cfg_wr_en | output | 1 | Gated write strobe toward the configuration bank |
| cfg_wr_addr | output | $clog2(BANK_SIZE) | Offset into the protected bank |
| cfg_wr_data | output | DATA_W | Data forwarded to the bank |
| req_accept | output | 1 | Memory controller may accept requests |
| cfg_locked | output | 1 | Software configuration lock state |
| sticky_locked | output | 1 | Sticky lock state |

## Verification
The bench targets the cases where the lock and unlock bits conflict. A design that let unlock win on data 11 would leave the bank writable. A design that cleared `req_accept` on unlock would stall memory traffic. A design whose unlock also released the sticky class would let writes through after a hardware lock. The bench also checks protected writes at the window's first and last addresses and writes just outside them, because a gate that is off by one would forward a stray write or drop a legal one. A behavioural reference model is compared with every output on every cycle, including across a reset in the middle of the run.

// File: rtl/cwl_pkg.sv
// Package: shared encodings for the configuration write-lock controller.
// Assumes: the control word carries the lock bit at position 0 and the
// unlock bit at position 1; every other data bit is ignored.
package cwl_pkg;

    // Bit positions inside the control word
    localparam int LOCK_POS   = 0;
    localparam int UNLOCK_POS = 1;

    // Command decoded from one control-word write
    typedef enum logic [1:0] {
        CMD_NONE   = 2'd0,
        CMD_LOCK   = 2'd1,
        CMD_UNLOCK = 2'd2
    } cwl_cmd_e;

endpackage

// File: rtl/cwl_ctl_decode.sv
// Module: cwl_ctl_decode
// Turns a write to the control word into a single command. The lock bit
// wins when both bits are set, and a write with neither bit set yields no
// command.
// Assumes: ctl_bits carries data bits [1:0] of the same write.
module cwl_ctl_decode
    import cwl_pkg::*;
#(
    parameter int                 ADDR_W   = 8,
    parameter logic [ADDR_W-1:0]  CTL_ADDR = 8'h90
) (
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [1:0]        ctl_bits,
    output cwl_cmd_e          cmd
);

    logic hit;

    // Purpose: detect a write aimed at the control word
    always_comb begin
        hit = wr_en && (wr_addr == CTL_ADDR);
    end

    // Purpose: pick the command, with lock taking priority over unlock
    always_comb begin
        cmd = CMD_NONE;
        if (hit) begin
            if (ctl_bits[LOCK_POS]) begin
                cmd = CMD_LOCK;
            end else if (ctl_bits[UNLOCK_POS]) begin
                cmd = CMD_UNLOCK;
            end
        end
    end

endmodule

// File: rtl/cwl_lock_state.sv
// Module: cwl_lock_state
// Holds three state bits. The first is the software configuration lock,
// which is set and cleared by commands. The second is the sticky lock,
// which a hardware request sets and only reset clears. The third is the
// request-accept flag, which the first lock command sets and only reset
// clears.
// Assumes: synchronous active-low reset.
module cwl_lock_state
    import cwl_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  cwl_cmd_e cmd,
    input  logic     sticky_req,
    output logic     locked,
    output logic     sticky,
    output logic     accept
);

    // Purpose: software lock follows lock and unlock commands
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            locked <= 1'b0;
        end else if (cmd == CMD_LOCK) begin
            locked <= 1'b1;
        end else if (cmd == CMD_UNLOCK) begin
            locked <= 1'b0;
        end
    end

    // Purpose: sticky lock, set by hardware request, released only by reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sticky <= 1'b0;
        end else if (sticky_req) begin
            sticky <= 1'b1;
        end
    end

    // Purpose: request acceptance opens on the first lock and stays open
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            accept <= 1'b0;
        end else if (cmd == CMD_LOCK) begin
            accept <= 1'b1;
        end
    end

endmodule

// File: rtl/cwl_wr_gate.sv
// Module: cwl_wr_gate
// Decodes writes that fall in the protected window and forwards them one
// cycle later, but only when no lock is held at the time of the write.
// Assumes: BANK_SIZE is a power of two of at least 2, and BANK_BASE is
// aligned to BANK_SIZE, so the offset is the low address bits.
module cwl_wr_gate #(
    parameter int                 ADDR_W    = 8,
    parameter int                 DATA_W    = 32,
    parameter logic [ADDR_W-1:0]  BANK_BASE = 8'h20,
    parameter int                 BANK_SIZE = 16,
    localparam int                BANK_AW   = $clog2(BANK_SIZE)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  wr_addr,
    input  logic [DATA_W-1:0]  wr_data,
    input  logic               blocked,
    output logic               out_en,
    output logic [BANK_AW-1:0] out_addr,
    output logic [DATA_W-1:0]  out_data
);

    localparam logic [ADDR_W-BANK_AW-1:0] BASE_HI = BANK_BASE[ADDR_W-1:BANK_AW];

    logic in_bank;
    logic pass;

    // Purpose: window decode by comparing the upper address bits
    always_comb begin
        in_bank = (wr_addr[ADDR_W-1:BANK_AW] == BASE_HI);
        pass    = wr_en && in_bank && !blocked;
    end

    // Purpose: registered write strobe toward the bank
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_en <= 1'b0;
        end else begin
            out_en <= pass;
        end
    end

    // Purpose: capture offset and data of an accepted write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_addr <= '0;
            out_data <= '0;
        end else if (pass) begin
            out_addr <= wr_addr[BANK_AW-1:0];
            out_data <= wr_data;
        end
    end

endmodule

// File: rtl/cwl_lock_ctrl.sv
// Module: cwl_lock_ctrl (top)
// Configuration write-lock controller. It decodes the control word, keeps
// the software lock, the sticky lock and the request-accept flag, and gates
// writes into the protected configuration bank.
// Assumes: CTL_ADDR lies outside the protected window, and the window is
// aligned to its power-of-two size.
module cwl_lock_ctrl
    import cwl_pkg::*;
#(
    parameter int                 ADDR_W    = 8,
    parameter int                 DATA_W    = 32,
    parameter logic [ADDR_W-1:0]  CTL_ADDR  = 8'h90,
    parameter logic [ADDR_W-1:0]  BANK_BASE = 8'h20,
    parameter int                 BANK_SIZE = 16,
    localparam int                BANK_AW   = $clog2(BANK_SIZE)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_wr_en,
    input  logic [ADDR_W-1:0]  reg_wr_addr,
    input  logic [DATA_W-1:0]  reg_wr_data,
    input  logic               sticky_lock_req,
    output logic               cfg_wr_en,
    output logic [BANK_AW-1:0] cfg_wr_addr,
    output logic [DATA_W-1:0]  cfg_wr_data,
    output logic               req_accept,
    output logic               cfg_locked,
    output logic               sticky_locked
);

    cwl_cmd_e cmd;
    logic     any_lock;

    cwl_ctl_decode #(
        .ADDR_W   (ADDR_W),
        .CTL_ADDR (CTL_ADDR)
    ) i_decode (
        .wr_en    (reg_wr_en),
        .wr_addr  (reg_wr_addr),
        .ctl_bits (reg_wr_data[1:0]),
        .cmd      (cmd)
    );

    cwl_lock_state i_state (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd        (cmd),
        .sticky_req (sticky_lock_req),
        .locked     (cfg_locked),
        .sticky     (sticky_locked),
        .accept     (req_accept)
    );

    // Purpose: any held lock class blocks the bank
    always_comb begin
        any_lock = cfg_locked || sticky_locked;
    end

    cwl_wr_gate #(
        .ADDR_W    (ADDR_W),
        .DATA_W    (DATA_W),
        .BANK_BASE (BANK_BASE),
        .BANK_SIZE (BANK_SIZE)
    ) i_gate (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (reg_wr_en),
        .wr_addr  (reg_wr_addr),
        .wr_data  (reg_wr_data),
        .blocked  (any_lock),
        .out_en   (cfg_wr_en),
        .out_addr (cfg_wr_addr),
        .out_data (cfg_wr_data)
    );

endmodule

// File: rtl/cwl_lock_ctrl_chk.sv
// Module: cwl_lock_ctrl_chk
// Temporal checks on the controller's ports, attached through bind.
module cwl_lock_ctrl_chk #(
    parameter int                 ADDR_W    = 8,
    parameter int                 DATA_W    = 32,
    parameter logic [ADDR_W-1:0]  CTL_ADDR  = 8'h90,
    parameter logic [ADDR_W-1:0]  BANK_BASE = 8'h20,
    parameter int                 BANK_SIZE = 16,
    localparam int                BANK_AW   = $clog2(BANK_SIZE)
) (
    input logic               clk,
    input logic               rst_n,
    input logic               reg_wr_en,
    input logic [ADDR_W-1:0]  reg_wr_addr,
    input logic [DATA_W-1:0]  reg_wr_data,
    input logic               sticky_lock_req,
    input logic               cfg_wr_en,
    input logic [BANK_AW-1:0] cfg_wr_addr,
    input logic [DATA_W-1:0]  cfg_wr_data,
    input logic               req_accept,
    input logic               cfg_locked,
    input logic               sticky_locked
);

    logic in_bank;
    logic ctl_wr;

    // Purpose: independent range and control-word decode for the properties
    always_comb begin
        in_bank = reg_wr_en && (int'(reg_wr_addr) >= int'(BANK_BASE))
                  && (int'(reg_wr_addr) < int'(BANK_BASE) + BANK_SIZE);
        ctl_wr  = reg_wr_en && (reg_wr_addr == CTL_ADDR);
    end

    // R4
    fwd_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_bank && !cfg_locked && !sticky_locked)
        |=> (cfg_wr_en && cfg_wr_data == $past(reg_wr_data)));

    // R5
    locked_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_bank && (cfg_locked || sticky_locked)) |=> !cfg_wr_en);

    // R2
    lock_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr && reg_wr_data[0]) |=> (cfg_locked && req_accept));

    // R6
    unlock_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr && reg_wr_data[1:0] == 2'b10) |=> !cfg_locked);

    // R3
    accept_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_accept && !(ctl_wr && reg_wr_data[0])) |=> !req_accept);

    // R8
    accept_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_accept |=> req_accept);

    // R9
    sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sticky_locked |=> sticky_locked);

    // R10
    stray_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_bank |=> !cfg_wr_en);

endmodule

bind cwl_lock_ctrl cwl_lock_ctrl_chk #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .CTL_ADDR  (CTL_ADDR),
    .BANK_BASE (BANK_BASE),
    .BANK_SIZE (BANK_SIZE)
) i_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .reg_wr_en       (reg_wr_en),
    .reg_wr_addr     (reg_wr_addr),
    .reg_wr_data     (reg_wr_data),
    .sticky_lock_req (sticky_lock_req),
    .cfg_wr_en       (cfg_wr_en),
    .cfg_wr_addr     (cfg_wr_addr),
    .cfg_wr_data     (cfg_wr_data),
    .req_accept      (req_accept),
    .cfg_locked      (cfg_locked),
    .sticky_locked   (sticky_locked)
);

// File: tb/test_cwl_lock_ctrl.sv
`timescale 1ns/1ps
// Bench: behavioural reference model compared on every falling edge,
// plus directed checks named by requirement.
module test_cwl_lock_ctrl;

    localparam int         ADDR_W = 8;
    localparam int         DATA_W = 32;
    localparam logic [7:0] CTL    = 8'h90;
    localparam int         BASE   = 32;
    localparam int         SIZE   = 16;
    localparam int         AW     = 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              reg_wr_en = 1'b0;
    logic [ADDR_W-1:0] reg_wr_addr = '0;
    logic [DATA_W-1:0] reg_wr_data = '0;
    logic              sticky_lock_req = 1'b0;
    logic              cfg_wr_en;
    logic [AW-1:0]     cfg_wr_addr;
    logic [DATA_W-1:0] cfg_wr_data;
    logic              req_accept;
    logic              cfg_locked;
    logic              sticky_locked;

    int    total = 0;
    int    bad = 0;
    bit    done = 1'b0;
    string cur_req = "R1";

    // Reference model state
    bit          m_lock, m_stk, m_acc, m_wen;
    int          m_waddr;
    logic [31:0] m_wdata;

    always #4 clk = ~clk;

    cwl_lock_ctrl i_cwl_lock_ctrl (
        .clk             (clk),
        .rst_n           (rst_n),
        .reg_wr_en       (reg_wr_en),
        .reg_wr_addr     (reg_wr_addr),
        .reg_wr_data     (reg_wr_data),
        .sticky_lock_req (sticky_lock_req),
        .cfg_wr_en       (cfg_wr_en),
        .cfg_wr_addr     (cfg_wr_addr),
        .cfg_wr_data     (cfg_wr_data),
        .req_accept      (req_accept),
        .cfg_locked      (cfg_locked),
        .sticky_locked   (sticky_locked)
    );

    // Reference model: updates from the inputs held across the rising edge
    always @(posedge clk) begin
        int  a;
        bit  inb, ctl;
        bit  nl, ns, na, nw;
        a   = int'(reg_wr_addr);
        inb = reg_wr_en && a >= BASE && a < BASE + SIZE;
        ctl = reg_wr_en && reg_wr_addr == CTL;
        if (!rst_n) begin
            m_lock = 0; m_stk = 0; m_acc = 0; m_wen = 0;
        end else begin
            nw = inb && !m_lock && !m_stk;
            nl = m_lock; na = m_acc; ns = m_stk || sticky_lock_req;
            if (ctl && reg_wr_data[0]) begin nl = 1; na = 1; end
            else if (ctl && reg_wr_data[1]) nl = 0;
            if (nw) begin m_waddr = a - BASE; m_wdata = reg_wr_data; end
            m_lock = nl; m_stk = ns; m_acc = na; m_wen = nw;
        end
    end

    task automatic chk(input string req, input string what, input longint act, input longint exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Per-cycle comparison against the model
    always @(negedge clk) begin
        if (!done) begin
            chk(cur_req, "cfg_locked", cfg_locked, m_lock);
            chk(cur_req, "sticky_locked", sticky_locked, m_stk);
            chk(cur_req, "req_accept", req_accept, m_acc);
            chk(cur_req, "cfg_wr_en", cfg_wr_en, m_wen);
            if (m_wen) begin
                chk(cur_req, "cfg_wr_addr", cfg_wr_addr, m_waddr);
                chk(cur_req, "cfg_wr_data", cfg_wr_data, m_wdata);
            end
        end
    end

    // Apply one cycle of input, then wait to the falling edge after it is taken
    task automatic cyc(input bit en, input int addr, input logic [31:0] data, input bit stk);
        reg_wr_en       = en;
        reg_wr_addr     = addr[7:0];
        reg_wr_data     = data;
        sticky_lock_req = stk;
        @(negedge clk);
        reg_wr_en       = 0;
        sticky_lock_req = 0;
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        $display("FAIL watchdog: run did not complete");
        finish_run();
    end

    initial begin
        @(negedge clk);
        @(negedge clk);
        // R1: state held in reset
        chk("R1", "locked in reset", cfg_locked, 0);
        chk("R1", "accept in reset", req_accept, 0);
        rst_n = 1;
        @(negedge clk);
        chk("R1", "wr_en after reset", cfg_wr_en, 0);
        chk("R1", "sticky after reset", sticky_locked, 0);

        // R4: unlocked writes at window edges are forwarded
        cur_req = "R4";
        cyc(1, BASE, 32'hA5A5_0001, 0);
        chk("R4", "first addr en", cfg_wr_en, 1);
        chk("R4", "first addr off", cfg_wr_addr, 0);
        cyc(1, BASE + SIZE - 1, 32'h1234_5678, 0);
        chk("R4", "last addr off", cfg_wr_addr, SIZE - 1);
        chk("R4", "last addr data", cfg_wr_data, 32'h1234_5678);

        // R10: stray writes just outside and control write of 00
        cur_req = "R10";
        cyc(1, BASE - 1, 32'hFFFF_FFFF, 0);
        chk("R10", "below window", cfg_wr_en, 0);
        cyc(1, BASE + SIZE, 32'hFFFF_FFFF, 0);
        chk("R10", "above window", cfg_wr_en, 0);
        cyc(1, CTL, 32'hFFFF_FFFC, 0);
        chk("R10", "ctl 00 lock", cfg_locked, 0);
        // R3: still no acceptance
        chk("R3", "accept before lock", req_accept, 0);
        cyc(1, CTL, 32'h2, 0);
        chk("R3", "accept after unlock-only", req_accept, 0);

        // R2: lock
        cur_req = "R2";
        cyc(1, CTL, 32'h1, 0);
        chk("R2", "locked", cfg_locked, 1);
        chk("R2", "accept", req_accept, 1);

        // R5: protected write dropped while locked
        cur_req = "R5";
        cyc(1, BASE + 3, 32'hDEAD_BEEF, 0);
        chk("R5", "locked drop", cfg_wr_en, 0);

        // R6/R8: unlock keeps acceptance
        cur_req = "R6";
        cyc(1, CTL, 32'h2, 0);
        chk("R6", "unlocked", cfg_locked, 0);
        chk("R8", "accept across unlock", req_accept, 1);
        cyc(1, BASE + 5, 32'hCAFE_0005, 0);
        chk("R6", "write after unlock", cfg_wr_en, 1);

        // R7: both bits set locks
        cur_req = "R7";
        cyc(1, CTL, 32'h3, 0);
        chk("R7", "both bits lock", cfg_locked, 1);
        cyc(1, BASE + 1, 32'h0BAD_0001, 0);
        chk("R7", "write dropped", cfg_wr_en, 0);

        // R9: sticky lock survives unlock
        cur_req = "R9";
        cyc(1, CTL, 32'h2, 1);
        chk("R9", "sticky set", sticky_locked, 1);
        chk("R9", "cfg unlocked", cfg_locked, 0);
        cyc(1, CTL, 32'h2, 0);
        chk("R9", "sticky after unlock", sticky_locked, 1);
        cyc(1, BASE + 2, 32'h5555_AAAA, 0);
        chk("R9", "sticky blocks write", cfg_wr_en, 0);
        chk("R8", "accept held", req_accept, 1);

        // R1: reset mid-run clears everything
        cur_req = "R1";
        rst_n = 0;
        @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk("R1", "sticky cleared by reset", sticky_locked, 0);
        chk("R1", "accept cleared by reset", req_accept, 0);

        // Mixed traffic compared against the model each cycle
        cur_req = "R8";
        for (int i = 0; i < 600; i++) begin
            int sel;
            int addr;
            sel = int'($urandom_range(0, 9));
            if (sel < 4)      addr = int'(CTL);
            else if (sel < 8) addr = BASE + int'($urandom_range(0, SIZE - 1));
            else              addr = int'($urandom_range(0, 255));
            cyc($urandom_range(0, 3) != 0, addr, $urandom, $urandom_range(0, 99) == 0);
        end

        finish_run();
    end

endmodule